// File: doc/BRIEF.md
# Quadrature Position Counter with Frozen Two-Byte Readout

This block turns the two phase-shifted channels of an incremental encoder into a 16-bit up/down position count. Both channels pass through rising-edge synchronisers. Every single-channel transition is counted, which is known as 4x decoding. Direction comes from which channel leads. A transition in which both channels change within one sample cannot be decoded, so it is discarded and a sticky error flag is raised.

A host reads the count one byte at a time over an 8-bit port. A byte-select input picks the byte, and an active-low output-enable input turns on the pad driver. On falling clock edges, an output latch normally copies the running count. When the host lowers select and output-enable together, the next falling edge freezes that latch. The high byte and the low byte then both come from one snapshot, while the counter keeps running underneath. Raising output-enable again releases the freeze.

Top module: `quad_latch_counter`

## Requirements
- R1: While `rst_n` is low, the count, the output latch and `dec_err` are zero. A read made after reset returns 0x0000 and `dec_err` reads 0.
- R2: With (A,B) stepping 00→10→11→01→00 (A leading), the count rises by one per transition. The reverse order (B leading) lowers it by one per transition.
- R3: The count wraps from 0xFFFF to 0x0000 going up, and from 0x0000 to 0xFFFF going down.
- R4: If A and B both change between two synchronised samples, the count is left unchanged. `dec_err` is then set and stays set until `rst_n` goes low.
- R5: `dout_oe` is the inverse of `oe_n` and follows it without a clock.
- R6: At the first falling clock edge where `oe_n` and `byte_sel` are both low, the output latch stops loading. It stays frozen while `oe_n` stays low, whatever `byte_sel` does. Both bytes of one read therefore come from the same count, even when the counter crosses a byte boundary during the read.
- R7: `dout` shows latch bits [15:8] when the `byte_sel` value taken at the last falling edge was 0, and bits [7:0] when it was 1.
- R8: The counter keeps counting while the latch is frozen. At the first falling edge with `oe_n` high, the latch loads the current count again.
- R9: Suppose an encoder input changes just after rising edge t0. A read whose select and enable go low just after rising edge t4 includes that change. A read started just after t3 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; synchronisers and counter on the rising edge, latch on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_a | input | 1 | Encoder channel A, asynchronous |
| chan_b | input | 1 | Encoder channel B, asynchronous |
| byte_sel | input | 1 | 0 selects the high byte, 1 selects the low byte |
| oe_n | input | 1 | Active-low output enable; low also requests the freeze |
| dout | output | 8 | Selected byte of the output latch |
| dout_oe | output | 1 | Pad driver enable for `dout`; low means high-impedance |
| dec_err | output | 1 | Sticky flag for an undecodable double transition |

## Verification
An encoder edge moves through two synchroniser stages and the counter register. It reaches the latch at the falling edge after the third rising edge, so it first shows up in a read started after the fourth rising edge. The bench checks both sides of that boundary.

Inputs are driven 2 ns after a rising edge. Byte results are sampled after the next rising edge, so the falling edge that updates the latch and the registered select has already passed. `dout_oe` is combinational and is checked 1 ns after `oe_n` changes. `dec_err` is checked three rising edges after the double transition is driven.

// File: rtl/quad_latch_counter.sv
`timescale 1ns/1ps
module quad_latch_counter #(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chan_a,
  input  logic                 chan_b,
  input  logic                 byte_sel,
  input  logic                 oe_n,
  output logic [CNT_W/2-1:0]   dout,
  output logic                 dout_oe,
  output logic                 dec_err
);
  localparam int BYTE_W = CNT_W / 2;

  logic [2:0]       a_sh, b_sh;
  logic             a_chg, b_chg, step_up;
  logic [CNT_W-1:0] cnt, latch;
  logic             inh, sel_q, hold;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_sh <= '0;
      b_sh <= '0;
    end else begin
      a_sh <= {a_sh[1:0], chan_a};
      b_sh <= {b_sh[1:0], chan_b};
    end

  assign a_chg   = a_sh[2] ^ a_sh[1];
  assign b_chg   = b_sh[2] ^ b_sh[1];
  assign step_up = a_chg ? (a_sh[1] ^ b_sh[1]) : ~(a_sh[1] ^ b_sh[1]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt     <= '0;
      dec_err <= 1'b0;
    end else begin
      if (a_chg ^ b_chg)
        cnt <= step_up ? cnt + CNT_W'(1) : cnt - CNT_W'(1);
      if (a_chg & b_chg)
        dec_err <= 1'b1;
    end

  assign hold = !oe_n && (inh || !byte_sel);

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      inh   <= 1'b0;
      latch <= '0;
      sel_q <= 1'b0;
    end else begin
      inh   <= hold;
      sel_q <= byte_sel;
      if (!hold)
        latch <= cnt;
    end

  assign dout    = sel_q ? latch[BYTE_W-1:0] : latch[CNT_W-1:BYTE_W];
  assign dout_oe = ~oe_n;

  a_r6_frozen_latch: assert property (@(negedge clk) disable iff (!rst_n)
    (inh && !oe_n) |=> $stable(latch));

  a_r4_double_change_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (a_chg && b_chg) |=> $stable(cnt));

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (a_chg != b_chg) |=> (cnt == $past(cnt) + CNT_W'(1) || cnt == $past(cnt) - CNT_W'(1)));

  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_chg && !b_chg) |=> $stable(cnt));

  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |=> dec_err);
endmodule

// File: tb/tb_quad_latch_counter.sv
`timescale 1ns/1ps
module tb_quad_latch_counter;
  logic       clk = 1'b0;
  logic       rst_n, chan_a, chan_b, byte_sel, oe_n;
  logic [7:0] dout;
  logic       dout_oe, dec_err;
  int         vectors = 0, miscompares = 0;
  int         phase = 0;
  logic [15:0] exp_cnt = 16'h0000;

  always #5 clk = ~clk;

  quad_latch_counter dut (
    .clk(clk), .rst_n(rst_n), .chan_a(chan_a), .chan_b(chan_b),
    .byte_sel(byte_sel), .oe_n(oe_n), .dout(dout), .dout_oe(dout_oe),
    .dec_err(dec_err));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic drive_phase();
    case (phase & 3)
      0: begin chan_a = 0; chan_b = 0; end
      1: begin chan_a = 1; chan_b = 0; end
      2: begin chan_a = 1; chan_b = 1; end
      default: begin chan_a = 0; chan_b = 1; end
    endcase
  endtask

  task automatic move(input int steps, input bit up);
    for (int i = 0; i < steps; i++) begin
      phase = up ? phase + 1 : phase + 3;
      drive_phase();
      exp_cnt = up ? exp_cnt + 16'd1 : exp_cnt - 16'd1;
      tick(1);
    end
    tick(4);
  endtask

  task automatic read_count(output logic [15:0] val);
    oe_n = 0; byte_sel = 0;
    tick(1);
    val[15:8] = dout;
    byte_sel = 1;
    tick(1);
    val[7:0] = dout;
    oe_n = 1;
    tick(1);
  endtask

  task automatic do_reset();
    rst_n = 0; oe_n = 1; byte_sel = 1; phase = 0; drive_phase(); exp_cnt = 0;
    tick(3);
    rst_n = 1;
    tick(2);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    check("R1 err after reset", {15'd0, dec_err}, 16'd0);
    read_count(v);
    check("R1 count after reset", v, 16'h0000);
  endtask

  task automatic t_oe();
    oe_n = 0; #1;
    check("R5 oe low enables", {15'd0, dout_oe}, 16'd1);
    oe_n = 1; #1;
    check("R5 oe high tristates", {15'd0, dout_oe}, 16'd0);
    tick(1);
  endtask

  task automatic t_latency();
    logic [15:0] v;
    phase = phase + 1; drive_phase();
    tick(3);
    read_count(v);
    check("R9 read after 3 edges misses step", v, exp_cnt);
    exp_cnt = exp_cnt + 16'd1;
    read_count(v);
    check("R9 later read includes step", v, exp_cnt);
    phase = phase + 1; drive_phase(); exp_cnt = exp_cnt + 16'd1;
    tick(4);
    read_count(v);
    check("R9 read after 4 edges includes step", v, exp_cnt);
  endtask

  task automatic t_direction();
    logic [15:0] v;
    move(8, 1'b1);
    read_count(v);
    check("R2 A-leading counts up", v, exp_cnt);
    move(5, 1'b0);
    read_count(v);
    check("R2 B-leading counts down", v, exp_cnt);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    move(int'(exp_cnt), 1'b0);
    read_count(v);
    check("R3 reached zero", v, 16'h0000);
    move(1, 1'b0);
    read_count(v);
    check("R3 wrap down", v, 16'hFFFF);
    move(1, 1'b1);
    read_count(v);
    check("R3 wrap up", v, 16'h0000);
  endtask

  task automatic t_coherent();
    logic [15:0] v;
    move(255, 1'b1);
    oe_n = 0; byte_sel = 0;
    tick(1);
    check("R7 high byte first", {8'h00, dout}, 16'h0000);
    phase = phase + 1; drive_phase(); exp_cnt = exp_cnt + 16'd1;
    tick(5);
    check("R6 high byte still frozen", {8'h00, dout}, 16'h0000);
    byte_sel = 1;
    tick(1);
    check("R6 low byte from same sample", {8'h00, dout}, 16'h00FF);
    byte_sel = 0;
    tick(1);
    check("R7 reselect high keeps frozen value", {8'h00, dout}, 16'h0000);
    oe_n = 1;
    tick(1);
    read_count(v);
    check("R8 count kept running during freeze", v, 16'h0100);
  endtask

  task automatic t_error();
    logic [15:0] v;
    phase = phase + 2; drive_phase();
    tick(3);
    check("R4 double change sets error", {15'd0, dec_err}, 16'd1);
    tick(2);
    read_count(v);
    check("R4 double change not counted", v, exp_cnt);
    move(2, 1'b1);
    check("R4 error sticky", {15'd0, dec_err}, 16'd1);
    read_count(v);
    check("R4 counting resumes", v, exp_cnt);
    do_reset();
    check("R1 reset clears error", {15'd0, dec_err}, 16'd0);
  endtask

  initial begin
    rst_n = 0; oe_n = 1; byte_sel = 1; chan_a = 0; chan_b = 0;
    t_reset();
    t_oe();
    t_latency();
    t_direction();
    t_wrap();
    t_coherent();
    t_error();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule